// File: doc/BRIEF.md
# Two-Port Shared Word Memory with Collision Arbitration

This block is a 2048-word by 16-bit memory that two independent controllers share. Each side has its own address, write data, read data, chip select, write enable and output enable. The two sides use it to pass data through common storage. Both sides run on one clock. A read returns its data one cycle after the request, and a valid flag marks that data.

Port A sees the memory in the address window 0x4000 to 0x47FF. Port B sees it at 0x0000 to 0x07FF. An access that falls outside a port's window is dropped. Two reads may hit the same word in the same cycle. If both sides touch the same word in one cycle and at least one of them is writing, the cycle is a collision. Port A always wins a collision. Port B's busy output rises in that same cycle, and its access is discarded.

Top module: `shared_word_ram`

## Requirements
- R1: A write on either port with select and write enable high stores the data. A later read of that word with select high, write enable low and output enable high returns the stored word on the next cycle, with that port's valid flag high in that cycle only.
- R2: In a cycle after which no read was accepted, the port's valid flag is low and its read data holds its previous value.
- R3: Both ports may read the same word in one cycle. Both get the word on the next cycle with both valid flags high, and no busy output rises.
- R4: If both ports write the same word in one cycle, port A's data is stored and port B's write is dropped. Port B's busy output is high in that cycle. Port A's busy output never rises.
- R5: If port A writes a word in the same cycle that port B reads it, port A's data is stored and port B's busy output is high in that cycle. Port B's valid flag stays low on the next cycle.
- R6: If port A reads a word in the same cycle that port B writes it, port B's busy output is high and port B's write is dropped. Port A returns the old content.
- R7: Writes from the two ports to different words in one cycle both complete. Accesses to different words never raise busy.
- R8: Port A maps address 0x4000+i to word i for i below 2048, and port B maps address i to word i. An access outside a port's window writes nothing, gives no valid flag and causes no busy.
- R9: While reset is asserted, both valid flags and both busy outputs are low and both read data outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by both sides |
| rst_n | input | 1 | Active-low reset |
| a_cs | input | 1 | Port A select |
| a_we | input | 1 | Port A write enable |
| a_oe | input | 1 | Port A output enable (a read when write enable is low) |
| a_addr | input | 16 | Port A bus address |
| a_wdata | input | 16 | Port A write data |
| a_rdata | output | 16 | Port A read data, one cycle latency |
| a_rvalid | output | 1 | Port A read data is valid |
| a_busy | output | 1 | Port A collision flag (A has priority, so it stays low) |
| b_cs | input | 1 | Port B select |
| b_we | input | 1 | Port B write enable |
| b_oe | input | 1 | Port B output enable |
| b_addr | input | 16 | Port B bus address |
| b_wdata | input | 16 | Port B write data |
| b_rdata | output | 16 | Port B read data, one cycle latency |
| b_rvalid | output | 1 | Port B read data is valid |
| b_busy | output | 1 | Port B lost a collision this cycle |

## Verification
The bench concentrates port addresses on a few words so that collisions of every kind happen often. It also places port A just outside its window on either side.

- A design that compared only the low address bits would let an out-of-window access alias into storage.
- A design that treated two reads as a collision would raise busy where none is due.
- A design that let port B write in a collision would leave B's data in the word, and a later read returns it.
- A design that handed port B the data in a read collision would raise its valid flag.

// File: rtl/srm_pkg.sv
package srm_pkg;

  // one decoded access request of a port
  typedef struct packed {
    logic rd;
    logic wr;
  } acc_t;

  // address lies within [base, base+depth)
  function automatic logic in_window(input logic [15:0] addr,
                                     input logic [15:0] base,
                                     input int depth);
    int a;
    int b;
    a = int'(addr);
    b = int'(base);
    return (a >= b) && (a < b + depth);
  endfunction

  // same word touched by both sides with at least one writer
  function automatic logic is_clash(input acc_t pa, input int ia,
                                    input acc_t pb, input int ib);
    return (pa.rd | pa.wr) && (pb.rd | pb.wr) && (ia == ib) && (pa.wr | pb.wr);
  endfunction

endpackage

// File: rtl/srm_decode.sv
module srm_decode
  import srm_pkg::*;
#(
  parameter int          AW    = 16,
  parameter int          DEPTH = 2048,
  parameter int          IW    = $clog2(DEPTH),
  parameter logic [15:0] BASE  = 16'h0000
) (
  input  logic          cs,
  input  logic          we,
  input  logic          oe,
  input  logic [AW-1:0] addr,
  output logic          hit,
  output acc_t          acc,
  output logic [IW-1:0] idx
);
  logic [AW-1:0] offs;

  always_comb begin
    hit    = in_window(16'(addr), BASE, DEPTH);
    offs   = addr - AW'(BASE);
    idx    = offs[IW-1:0];
    acc.wr = cs & hit & we;
    acc.rd = cs & hit & ~we & oe;
  end
endmodule

// File: rtl/srm_arbiter.sv
module srm_arbiter
  import srm_pkg::*;
#(
  parameter int IW = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  acc_t          a_acc,
  input  logic [IW-1:0] a_idx,
  input  acc_t          b_acc,
  input  logic [IW-1:0] b_idx,
  output acc_t          a_gnt,
  output acc_t          b_gnt,
  output logic          b_busy
);
  logic clash;

  always_comb begin
    clash  = is_clash(a_acc, int'(a_idx), b_acc, int'(b_idx));
    a_gnt  = a_acc;
    b_gnt  = clash ? '0 : b_acc;
    b_busy = clash;
  end

  AST_DUAL_READ_NO_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (a_acc.rd && b_acc.rd && a_idx == b_idx) |-> (!b_busy && b_gnt.rd)); // R3

  AST_DIFF_WORD_NO_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (a_idx != b_idx) |-> (!b_busy && b_gnt == b_acc)); // R7
endmodule

// File: rtl/srm_storage.sv
module srm_storage #(
  parameter int DW    = 16,
  parameter int DEPTH = 2048,
  parameter int IW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_a,
  input  logic          rd_a,
  input  logic [IW-1:0] idx_a,
  input  logic [DW-1:0] din_a,
  input  logic          wr_b,
  input  logic          rd_b,
  input  logic [IW-1:0] idx_b,
  input  logic [DW-1:0] din_b,
  output logic [DW-1:0] dout_a,
  output logic          vld_a,
  output logic [DW-1:0] dout_b,
  output logic          vld_b
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_a) mem[idx_a] <= din_a;
    if (wr_b) mem[idx_b] <= din_b;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dout_a <= '0;
      vld_a  <= 1'b0;
      dout_b <= '0;
      vld_b  <= 1'b0;
    end else begin
      vld_a <= rd_a;
      vld_b <= rd_b;
      if (rd_a) dout_a <= mem[idx_a];
      if (rd_b) dout_b <= mem[idx_b];
    end
  end

  AST_NO_TWIN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_a && wr_b && idx_a == idx_b)); // R4

  AST_NO_READ_ON_WRITTEN_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    !((wr_a && rd_b && idx_a == idx_b) || (wr_b && rd_a && idx_a == idx_b))); // R5
endmodule

// File: rtl/shared_word_ram.sv
module shared_word_ram
  import srm_pkg::*;
#(
  parameter int          AW     = 16,
  parameter int          DW     = 16,
  parameter int          DEPTH  = 2048,
  parameter logic [15:0] A_BASE = 16'h4000,
  parameter logic [15:0] B_BASE = 16'h0000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          a_cs,
  input  logic          a_we,
  input  logic          a_oe,
  input  logic [AW-1:0] a_addr,
  input  logic [DW-1:0] a_wdata,
  output logic [DW-1:0] a_rdata,
  output logic          a_rvalid,
  output logic          a_busy,
  input  logic          b_cs,
  input  logic          b_we,
  input  logic          b_oe,
  input  logic [AW-1:0] b_addr,
  input  logic [DW-1:0] b_wdata,
  output logic [DW-1:0] b_rdata,
  output logic          b_rvalid,
  output logic          b_busy
);
  localparam int NP = 2;
  localparam int IW = $clog2(DEPTH);
  localparam logic [NP-1:0][15:0] BASES = {B_BASE, A_BASE};

  logic [NP-1:0]          p_cs, p_we, p_oe, p_hit;
  logic [NP-1:0][AW-1:0]  p_addr;
  logic [NP-1:0][IW-1:0]  p_idx;
  acc_t [NP-1:0]          p_acc;
  acc_t                   a_gnt, b_gnt;

  assign p_cs   = {b_cs, a_cs};
  assign p_we   = {b_we, a_we};
  assign p_oe   = {b_oe, a_oe};
  assign p_addr = {b_addr, a_addr};

  for (genvar p = 0; p < NP; p++) begin : g_dec
    srm_decode #(.AW(AW), .DEPTH(DEPTH), .IW(IW), .BASE(BASES[p])) dec_i (
      .cs(p_cs[p]), .we(p_we[p]), .oe(p_oe[p]), .addr(p_addr[p]),
      .hit(p_hit[p]), .acc(p_acc[p]), .idx(p_idx[p]));
  end

  srm_arbiter #(.IW(IW)) arb_i (
    .clk(clk), .rst_n(rst_n),
    .a_acc(p_acc[0]), .a_idx(p_idx[0]),
    .b_acc(p_acc[1]), .b_idx(p_idx[1]),
    .a_gnt(a_gnt), .b_gnt(b_gnt), .b_busy(b_busy));

  assign a_busy = 1'b0;

  srm_storage #(.DW(DW), .DEPTH(DEPTH), .IW(IW)) mem_i (
    .clk(clk), .rst_n(rst_n),
    .wr_a(a_gnt.wr), .rd_a(a_gnt.rd), .idx_a(p_idx[0]), .din_a(a_wdata),
    .wr_b(b_gnt.wr), .rd_b(b_gnt.rd), .idx_b(p_idx[1]), .din_b(b_wdata),
    .dout_a(a_rdata), .vld_a(a_rvalid), .dout_b(b_rdata), .vld_b(b_rvalid));

  AST_BUSY_BLOCKS_B: assert property (@(posedge clk) disable iff (!rst_n)
    b_busy |-> (!b_gnt.wr && !b_gnt.rd)); // R4

  AST_BUSY_NEEDS_A: assert property (@(posedge clk) disable iff (!rst_n)
    b_busy |-> (p_acc[0].rd || p_acc[0].wr)); // R6

  AST_B_VALID_AFTER_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    b_gnt.rd |=> b_rvalid); // R1

  AST_A_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !a_gnt.rd |=> (!a_rvalid && $stable(a_rdata))); // R2

  AST_OUTSIDE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !p_hit[0] |-> (!a_gnt.wr && !a_gnt.rd && !b_busy)); // R8
endmodule

// File: tb/shared_word_ram_tb.sv
`timescale 1ns/1ps
module shared_word_ram_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        a_cs = 0, a_we = 0, a_oe = 0, b_cs = 0, b_we = 0, b_oe = 0;
  logic [15:0] a_addr = 0, a_wdata = 0, b_addr = 0, b_wdata = 0;
  logic [15:0] a_rdata, b_rdata;
  logic        a_rvalid, b_rvalid, a_busy, b_busy;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  logic [15:0] model [2048];
  bit          known [2048];

  always #4 clk = ~clk;

  shared_word_ram dut_i (
    .clk(clk), .rst_n(rst_n),
    .a_cs(a_cs), .a_we(a_we), .a_oe(a_oe), .a_addr(a_addr), .a_wdata(a_wdata),
    .a_rdata(a_rdata), .a_rvalid(a_rvalid), .a_busy(a_busy),
    .b_cs(b_cs), .b_we(b_we), .b_oe(b_oe), .b_addr(b_addr), .b_wdata(b_wdata),
    .b_rdata(b_rdata), .b_rvalid(b_rvalid), .b_busy(b_busy));

  function automatic bit a_in(input logic [15:0] ad);
    return ad >= 16'h4000 && ad < 16'h4800;
  endfunction
  function automatic bit b_in(input logic [15:0] ad);
    return ad < 16'h0800;
  endfunction

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // apply one cycle of traffic at a falling edge, check busy, then results
  task automatic op(input string tag,
                    input bit acs, input bit awe, input bit aoe, input logic [15:0] aad, input logic [15:0] awd,
                    input bit bcs, input bit bwe, input bit boe, input logic [15:0] bad, input logic [15:0] bwd);
    bit ar, aw, br, bw, clash;
    int ai, bi;
    logic [15:0] ea, eb, pa, pb;
    bit ka, kb;
    ai = int'(aad) - 16'h4000;
    bi = int'(bad);
    aw = acs && awe && a_in(aad);
    ar = acs && !awe && aoe && a_in(aad);
    bw = bcs && bwe && b_in(bad);
    br = bcs && !bwe && boe && b_in(bad);
    clash = (aw || ar) && (bw || br) && (ai == bi) && (aw || bw);
    if (clash) begin bw = 0; br = 0; end
    ea = ar ? model[ai[10:0]] : 16'h0; ka = ar && known[ai[10:0]];
    eb = br ? model[bi[10:0]] : 16'h0; kb = br && known[bi[10:0]];
    pa = a_rdata; pb = b_rdata;
    a_cs = acs; a_we = awe; a_oe = aoe; a_addr = aad; a_wdata = awd;
    b_cs = bcs; b_we = bwe; b_oe = boe; b_addr = bad; b_wdata = bwd;
    #1;
    chk(tag, "b_busy", int'(b_busy), int'(clash));
    chk(tag, "a_busy", int'(a_busy), 0);
    @(posedge clk);
    @(negedge clk);
    if (aw) begin model[ai[10:0]] = awd; known[ai[10:0]] = 1; end
    if (bw) begin model[bi[10:0]] = bwd; known[bi[10:0]] = 1; end
    chk(tag, "a_rvalid", int'(a_rvalid), int'(ar));
    chk(tag, "b_rvalid", int'(b_rvalid), int'(br));
    if (ka) chk(tag, "a_rdata", int'(a_rdata), int'(ea));
    if (kb) chk(tag, "b_rdata", int'(b_rdata), int'(eb));
    if (!ar) chk("R2", "a_rdata hold", int'(a_rdata), int'(pa));
    if (!br) chk("R2", "b_rdata hold", int'(b_rdata), int'(pb));
    a_cs = 0; b_cs = 0;
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'h5eed);
    repeat (3) @(negedge clk);
    chk("R9", "a_rvalid", int'(a_rvalid), 0);
    chk("R9", "b_rvalid", int'(b_rvalid), 0);
    chk("R9", "b_busy", int'(b_busy), 0);
    chk("R9", "a_rdata", int'(a_rdata), 0);
    chk("R9", "b_rdata", int'(b_rdata), 0);
    rst_n = 1;
    @(negedge clk);
    // R1 basic write and read on each side
    op("R1", 1,1,0,16'h4005,16'hA5A5, 1,1,0,16'h0006,16'h5A5A);
    op("R1", 1,0,1,16'h4006,16'h0, 1,0,1,16'h0005,16'h0);
    op("R2", 0,0,0,16'h4006,16'h0, 0,0,0,16'h0005,16'h0);
    // R3 same word dual read
    op("R3", 1,0,1,16'h4005,16'h0, 1,0,1,16'h0005,16'h0);
    // R4 dual write same word, then read back
    op("R4", 1,1,0,16'h4010,16'h1111, 1,1,0,16'h0010,16'h2222);
    op("R4", 0,0,0,16'h0,16'h0, 1,0,1,16'h0010,16'h0);
    // R5 A writes, B reads same word
    op("R5", 1,1,0,16'h4020,16'h3333, 1,0,1,16'h0020,16'h0);
    // R6 A reads, B writes same word
    op("R6", 1,0,1,16'h4020,16'h0, 1,1,0,16'h0020,16'h4444);
    op("R6", 1,0,1,16'h4020,16'h0, 0,0,0,16'h0,16'h0);
    // R7 different words both written
    op("R7", 1,1,0,16'h4030,16'h7777, 1,1,0,16'h0031,16'h8888);
    op("R7", 1,0,1,16'h4031,16'h0, 1,0,1,16'h0030,16'h0);
    // R8 window edges and out-of-window
    op("R8", 1,1,0,16'h47FF,16'hBEEF, 1,1,0,16'h07FE,16'hCAFE);
    op("R8", 1,1,0,16'h3FFF,16'hDEAD, 1,1,0,16'h07FF,16'h0F0F);
    op("R8", 1,1,0,16'h4800,16'hDEAD, 1,0,1,16'h07FF,16'h0);
    op("R8", 1,0,1,16'h47FF,16'h0, 1,0,1,16'h07FE,16'h0);
    op("R8", 1,0,1,16'h3FFF,16'h0, 1,1,0,16'h0800,16'h1234);
    // random traffic over a small word pool
    for (int n = 0; n < 3000; n++) begin
      logic [15:0] aa, ba;
      int r;
      r = int'($urandom % 16);
      aa = (r == 0) ? 16'h3FF8 + 16'($urandom % 8) :
           (r == 1) ? 16'h4800 + 16'($urandom % 8) : 16'h4000 + 16'($urandom % 8);
      ba = (r == 2) ? 16'h0800 + 16'($urandom % 8) : 16'($urandom % 8);
      op("R7", 1'($urandom), 1'($urandom), 1'($urandom), aa, 16'($urandom),
               1'($urandom), 1'($urandom), 1'($urandom), ba, 16'($urandom));
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule